// File: doc/BRIEF.md
# Write-Commit Register Buffer

This block sits between the write decode of a register bank and the field storage of a group of wide registers. A software write to any of these registers does not touch the fields directly. It is held in a private holding stage for that register, together with a per-bit enable mask and a pending flag. Several writes can land in the holding stage before anything becomes visible. These writes may be narrow sub-word writes, byte-strobed writes, or writes that overwrite each other. The accumulated bits are applied to the fields only when the register's commit trigger fires. This makes a multi-cycle update of a wide register, or of a set of registers, appear to hardware as a single-cycle change.

Each register picks one of three trigger kinds at build time:
- **Self:** a write to its own highest sub-word, which is also merged into the commit.
- **Peer:** a write to the highest sub-word of a named peer register. Every register that names the same peer commits in the same cycle.
- **External:** a level on an external line, with the polarity chosen per line.

A trigger that finds nothing pending does nothing. A commit raises the register's commit strobe during the commit cycle, and the fields show the new value from the next cycle.

Each register slot runs a two-state machine:
- States are `ST_IDLE` (nothing buffered) and `ST_PEND` (buffered bits waiting).
- Transition *capture* (`ST_IDLE`→`ST_PEND`): a write with at least one byte enabled and no commit.
- Transition *accumulate* (`ST_PEND`→`ST_PEND`): a further write without a commit.
- Transition *drain* (`ST_PEND`→`ST_IDLE`): a commit with no new write for a peer or external slot, or any commit for a self slot.
- Transition *restart* (`ST_PEND`→`ST_PEND`): a commit in a peer or external slot that coincides with a new write. The new write becomes the next transaction.
- Transition *direct* (`ST_IDLE`→`ST_IDLE`): a self-slot top sub-word write that commits at once.

Top module: `wcommit_buf`

## Requirements
- R1: A buffered write does not change the register's field output; fields change only in a cycle that follows a commit.
- R2: For a self-triggered register, a write to its highest sub-word (sub-word SUBW-1) commits everything buffered, merged with the enabled bytes of that same write. The new value appears on the field output in the next cycle.
- R3: For peer-triggered registers, a write to the highest sub-word of the peer commits every pending register that names that peer, all in the same cycle.
- R4: An external trigger commits a pending register while its line is at the active level. EXT_LOW bit k = 1 makes line k active low, and 0 makes it active high. Fields show the new value in the cycle after the trigger cycle.
- R5: A trigger for a register with nothing pending is ignored. The commit strobe stays low and the fields are unchanged.
- R6: Strobe bit k enables data bits 8k..8k+7 of the bus word. Only enabled bits are committed, and every other field bit keeps its value.
- R7: Buffered writes accumulate: enabled bits are OR-ed into the mask, and a later write to the same bits replaces the earlier buffered data.
- R8: commit_o bit i is high exactly in the cycle in which register i commits, and is low on cycles that only buffer data.
- R9: In a peer- or external-triggered register, a write in the commit cycle is not part of that commit. It starts a new pending transaction, which the next trigger commits.
- R10: Reset returns every field to FIELD_RST and clears all pending state, so a trigger straight after reset is ignored.
- R11: Register i sub-word s sits at address i*SUBW+s, and sub-word 0 holds the least significant bits. Addresses at or above NREG*SUBW are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Software write request this cycle |
| wr_addr | input | AW | Sub-word address of the write |
| wr_data | input | BUS_W | Write data |
| wr_strb | input | BUS_W/8 | Byte enables of the write |
| ext_trig | input | NEXT | External commit lines, polarity per EXT_LOW |
| fld_o | output | NREG*REG_W | Field contents, register i at bits i*REG_W upward |
| commit_o | output | NREG | Per-register commit strobe |

## Verification
The hardest case to reach from the ports is a commit in the same cycle as a new write to the committing register. The trigger and the write must coincide, and the design has only one write port. The directed stimulus uses an external-trigger register for this. It holds the external line active during the very cycle that writes the register's high sub-word. It then checks that only the earlier low half was applied, and that a second pulse applies the high half. A third pulse checks that the slot has drained.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } wcb_state_e;

    localparam int TK_SELF = 0;
    localparam int TK_PEER = 1;
    localparam int TK_EXT  = 2;

endpackage

// File: rtl/wcb_decode.sv
module wcb_decode #(
    parameter int NREG   = 6,
    parameter int SUBW   = 2,
    parameter int BUS_W  = 16,
    parameter int AW     = 4,
    parameter int SUBW_W = 1,
    localparam int SW    = BUS_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [SW-1:0]     wr_strb,
    output logic [NREG-1:0]   hit,
    output logic [NREG-1:0]   top_hit,
    output logic [SUBW_W-1:0] sub,
    output logic [BUS_W-1:0]  bmask
);
    localparam int unsigned SUBW_U = SUBW;
    localparam int unsigned LIMIT  = NREG * SUBW;

    logic [31:0] addr_w;
    logic [31:0] reg_idx;
    logic        in_range;

    always_comb begin
        addr_w   = 32'(wr_addr);
        in_range = wr_en && (addr_w < LIMIT);
        reg_idx  = addr_w / SUBW_U;
        sub      = SUBW_W'(addr_w % SUBW_U);
        for (int i = 0; i < NREG; i++) begin
            hit[i]     = in_range && (reg_idx == 32'(i));
            top_hit[i] = hit[i] && (32'(sub) == SUBW_U - 1);
        end
    end

    genvar b;
    generate
        for (b = 0; b < SW; b++) begin : g_bmask
            assign bmask[8*b +: 8] = {8{wr_strb[b]}};
        end
    endgenerate

    assert_onehot_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    assert_top_in_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (top_hit & ~hit) == '0);

endmodule

// File: rtl/wcb_trig_sel.sv
module wcb_trig_sel #(
    parameter int NREG = 6,
    parameter int NEXT = 2,
    parameter int KIND = 0,
    parameter int IDX  = 0,
    parameter int OWN  = 0,
    parameter logic [NEXT-1:0] EXT_LOW = '0
) (
    input  logic [NREG-1:0] top_hit,
    input  logic [NEXT-1:0] ext_trig,
    output logic            trig
);
    import wcb_pkg::*;

    localparam int SRC = (KIND == TK_SELF) ? OWN : IDX;
    localparam logic [NREG-1:0] HIT_SEL = NREG'(1) << SRC;
    localparam logic [NEXT-1:0] EXT_SEL = NEXT'(1) << IDX;

    logic hit_term;
    logic ext_term;

    assign hit_term = |(top_hit & HIT_SEL);
    assign ext_term = |((ext_trig ^ EXT_LOW) & EXT_SEL);

    generate
        if (KIND == TK_EXT) begin : g_ext
            assign trig = ext_term;
        end else begin : g_hit
            assign trig = hit_term;
        end
    endgenerate

endmodule

// File: rtl/wcb_slot.sv
module wcb_slot #(
    parameter int REG_W  = 32,
    parameter int BUS_W  = 16,
    parameter int SUBW_W = 1,
    parameter int SELF   = 1,
    parameter logic [REG_W-1:0] FIELD_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [SUBW_W-1:0] wr_sub,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [BUS_W-1:0]  wr_bmask,
    input  logic              trig,
    output logic [REG_W-1:0]  fld_o,
    output logic              commit_o
);
    import wcb_pkg::*;

    wcb_state_e       state_q, state_d;
    logic [REG_W-1:0] buf_data_q, buf_mask_q;
    logic [REG_W-1:0] buf_data_d, buf_mask_d;
    logic [REG_W-1:0] fld_q, fld_d;
    logic [REG_W-1:0] inc_data, inc_mask;
    logic [REG_W-1:0] mrg_data, mrg_mask;
    logic [REG_W-1:0] cm_data, cm_mask;
    logic             wr_any;
    logic             take_new;
    logic             commit;

    // place the incoming bus word at its sub-word position
    always_comb begin
        inc_data = '0;
        inc_mask = '0;
        if (wr_hit) begin
            inc_data[32'(wr_sub)*BUS_W +: BUS_W] = wr_data;
            inc_mask[32'(wr_sub)*BUS_W +: BUS_W] = wr_bmask;
        end
        wr_any   = wr_hit && (|wr_bmask);
        mrg_mask = buf_mask_q | inc_mask;
        mrg_data = (buf_data_q & ~inc_mask) | (inc_data & inc_mask);
    end

    generate
        if (SELF != 0) begin : g_self
            assign commit   = trig && ((state_q == ST_PEND) || wr_any);
            assign cm_data  = mrg_data;
            assign cm_mask  = mrg_mask;
            assign take_new = 1'b0;
        end else begin : g_other
            assign commit   = trig && (state_q == ST_PEND);
            assign cm_data  = buf_data_q;
            assign cm_mask  = buf_mask_q;
            assign take_new = wr_any;
        end
    endgenerate

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_any && !commit) state_d = ST_PEND;
            ST_PEND: if (commit)            state_d = take_new ? ST_PEND : ST_IDLE;
        endcase
    end

    // datapath outputs
    always_comb begin
        buf_data_d = buf_data_q;
        buf_mask_d = buf_mask_q;
        fld_d      = fld_q;
        if (commit) begin
            fld_d = (fld_q & ~cm_mask) | (cm_data & cm_mask);
            if (take_new) begin
                buf_data_d = inc_data & inc_mask;
                buf_mask_d = inc_mask;
            end else begin
                buf_data_d = '0;
                buf_mask_d = '0;
            end
        end else if (wr_any) begin
            buf_data_d = mrg_data;
            buf_mask_d = mrg_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_data_q <= '0;
            buf_mask_q <= '0;
            fld_q      <= FIELD_RST;
        end else begin
            buf_data_q <= buf_data_d;
            buf_mask_q <= buf_mask_d;
            fld_q      <= fld_d;
        end
    end

    assign fld_o    = fld_q;
    assign commit_o = commit;

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_o |=> $stable(fld_o));
    assert_idle_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wr_any) |-> !commit_o);
    assert_keep_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> ((fld_o ^ $past(fld_o)) & ~$past(cm_mask)) == '0);
    assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !commit_o) |=> (state_q == ST_PEND));
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && wr_any) |=> (state_q == ((SELF != 0) ? ST_IDLE : ST_PEND)));

endmodule

// File: rtl/wcommit_buf.sv
module wcommit_buf #(
    parameter int NREG  = 6,
    parameter int REG_W = 32,
    parameter int BUS_W = 16,
    parameter int NEXT  = 2,
    parameter logic [2*NREG-1:0] TRIG_KIND = {2'd2, 2'd2, 2'd0, 2'd1, 2'd1, 2'd0},
    parameter logic [8*NREG-1:0] TRIG_IDX  = {8'd1, 8'd0, 8'd0, 8'd3, 8'd3, 8'd0},
    parameter logic [NEXT-1:0]   EXT_LOW   = 2'b10,
    parameter logic [REG_W-1:0]  FIELD_RST = 32'hA5A5_0000,
    localparam int SUBW   = REG_W / BUS_W,
    localparam int SUBW_W = (SUBW > 1) ? $clog2(SUBW) : 1,
    localparam int AW     = (NREG * SUBW > 1) ? $clog2(NREG * SUBW) : 1,
    localparam int SW     = BUS_W / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [BUS_W-1:0]      wr_data,
    input  logic [SW-1:0]         wr_strb,
    input  logic [NEXT-1:0]       ext_trig,
    output logic [NREG*REG_W-1:0] fld_o,
    output logic [NREG-1:0]       commit_o
);
    import wcb_pkg::*;

    logic [NREG-1:0]   hit;
    logic [NREG-1:0]   top_hit;
    logic [SUBW_W-1:0] sub;
    logic [BUS_W-1:0]  bmask;
    logic [NREG-1:0]   trig;

    wcb_decode #(
        .NREG(NREG), .SUBW(SUBW), .BUS_W(BUS_W), .AW(AW), .SUBW_W(SUBW_W)
    ) decode_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_strb(wr_strb), .hit(hit), .top_hit(top_hit), .sub(sub), .bmask(bmask)
    );

    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_reg
            localparam int KIND = int'(TRIG_KIND[2*i +: 2]);

            wcb_trig_sel #(
                .NREG(NREG), .NEXT(NEXT), .KIND(KIND),
                .IDX(int'(TRIG_IDX[8*i +: 8])), .OWN(i), .EXT_LOW(EXT_LOW)
            ) sel_i (
                .top_hit(top_hit), .ext_trig(ext_trig), .trig(trig[i])
            );

            wcb_slot #(
                .REG_W(REG_W), .BUS_W(BUS_W), .SUBW_W(SUBW_W),
                .SELF((KIND == TK_SELF) ? 1 : 0), .FIELD_RST(FIELD_RST)
            ) slot_i (
                .clk(clk), .rst_n(rst_n), .wr_hit(hit[i]), .wr_sub(sub),
                .wr_data(wr_data), .wr_bmask(bmask), .trig(trig[i]),
                .fld_o(fld_o[i*REG_W +: REG_W]), .commit_o(commit_o[i])
            );

            assert_commit_needs_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
                commit_o[i] |-> trig[i]);
        end
    endgenerate

endmodule

// File: tb/wcommit_buf_tb.sv
module wcommit_buf_tb_top;
    localparam int    NREG     = 6;
    localparam int    REG_W    = 32;
    localparam time   CLK_P    = 4ns;
    localparam logic [1:0]  EXT_IDLE = 2'b10;
    localparam logic [31:0] RSTV     = 32'hA5A5_0000;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  wr_en = 1'b0;
    logic [3:0]            wr_addr = '0;
    logic [15:0]           wr_data = '0;
    logic [1:0]            wr_strb = '0;
    logic [1:0]            ext_trig = EXT_IDLE;
    logic [NREG*REG_W-1:0] fld_o;
    logic [NREG-1:0]       commit_o;

    int total = 0;
    int bad   = 0;
    logic [NREG-1:0]       last_cm;
    logic [NREG*REG_W-1:0] last_pre;

    always #(CLK_P/2) clk = ~clk;

    wcommit_buf dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_strb(wr_strb), .ext_trig(ext_trig),
        .fld_o(fld_o), .commit_o(commit_o)
    );

    function automatic logic [31:0] fld(input int i);
        return fld_o[i*REG_W +: REG_W];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // one bus cycle; commit strobe and pre-edge fields captured mid-cycle
    task automatic step(input logic en, input logic [3:0] a, input logic [15:0] d,
                        input logic [1:0] s, input logic [1:0] ex);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; wr_strb = s; ext_trig = ex;
        #1;
        last_cm  = commit_o;
        last_pre = fld_o;
        @(negedge clk);
        wr_en = 1'b0; ext_trig = EXT_IDLE;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        for (int i = 0; i < NREG; i++) chk("R10", "reset field", 64'(fld(i)), 64'(RSTV));
        chk("R10", "reset commit", 64'(commit_o), 64'd0);
        step(1'b0, 4'd0, 16'd0, 2'b00, 2'b11);
        chk("R10", "ext after reset ignored", 64'(last_cm), 64'd0);
        chk("R5", "reg4 kept", 64'(fld(4)), 64'(RSTV));
    endtask

    task automatic t_ignore_peer();
        step(1'b1, 4'd7, 16'h1234, 2'b11, EXT_IDLE);
        chk("R5", "only reg3 commits", 64'(last_cm), 64'b001000);
        chk("R2", "reg3 value", 64'(fld(3)), 64'h1234_0000);
        chk("R5", "reg1 untouched", 64'(fld(1)), 64'(RSTV));
    endtask

    task automatic t_self();
        step(1'b1, 4'd0, 16'hBEEF, 2'b11, EXT_IDLE);
        chk("R8", "no strobe on buffering", 64'(last_cm), 64'd0);
        chk("R1", "reg0 held", 64'(fld(0)), 64'(RSTV));
        step(1'b1, 4'd1, 16'hCAFE, 2'b11, EXT_IDLE);
        chk("R2", "self commit strobe", 64'(last_cm), 64'b000001);
        chk("R2", "reg0 pre-edge old", 64'(last_pre[31:0]), 64'(RSTV));
        chk("R2", "reg0 committed", 64'(fld(0)), 64'hCAFE_BEEF);
    endtask

    task automatic t_peer_group();
        step(1'b1, 4'd2, 16'h1111, 2'b11, EXT_IDLE);
        step(1'b1, 4'd5, 16'h2222, 2'b11, EXT_IDLE);
        step(1'b1, 4'd6, 16'h3333, 2'b11, EXT_IDLE);
        chk("R1", "group held", 64'(last_cm), 64'd0);
        chk("R1", "reg1 held", 64'(fld(1)), 64'(RSTV));
        step(1'b1, 4'd7, 16'h4444, 2'b11, EXT_IDLE);
        chk("R3", "group commit same cycle", 64'(last_cm), 64'b001110);
        chk("R3", "reg1", 64'(fld(1)), 64'hA5A5_1111);
        chk("R3", "reg2", 64'(fld(2)), 64'h2222_0000);
        chk("R3", "reg3", 64'(fld(3)), 64'h4444_3333);
    endtask

    task automatic t_strobe();
        step(1'b1, 4'd0, 16'h0012, 2'b01, EXT_IDLE);
        step(1'b1, 4'd1, 16'h5600, 2'b10, EXT_IDLE);
        chk("R6", "strobed merge", 64'(fld(0)), 64'h56FE_BE12);
    endtask

    task automatic t_accum_ext_high();
        step(1'b1, 4'd8, 16'h00AA, 2'b01, EXT_IDLE);
        step(1'b1, 4'd8, 16'hBB00, 2'b10, EXT_IDLE);
        step(1'b1, 4'd8, 16'h00CC, 2'b01, EXT_IDLE);
        step(1'b1, 4'd9, 16'h7777, 2'b11, EXT_IDLE);
        chk("R1", "ext reg held after top write", 64'(fld(4)), 64'(RSTV));
        step(1'b0, 4'd0, 16'd0, 2'b00, 2'b11);
        chk("R4", "active-high commit", 64'(last_cm), 64'b010000);
        chk("R4", "pre-edge old value", 64'(last_pre[4*32 +: 32]), 64'(RSTV));
        chk("R7", "accumulated value", 64'(fld(4)), 64'h7777_BBCC);
    endtask

    task automatic t_ext_low();
        step(1'b1, 4'd10, 16'h0101, 2'b11, EXT_IDLE);
        step(1'b0, 4'd0, 16'd0, 2'b00, 2'b10);
        chk("R4", "inactive high level", 64'(last_cm), 64'd0);
        step(1'b0, 4'd0, 16'd0, 2'b00, 2'b00);
        chk("R4", "active-low commit", 64'(last_cm), 64'b100000);
        chk("R4", "reg5 value", 64'(fld(5)), 64'hA5A5_0101);
    endtask

    task automatic t_overlap();
        step(1'b1, 4'd8, 16'h1357, 2'b11, EXT_IDLE);
        step(1'b1, 4'd9, 16'h2468, 2'b11, 2'b11);
        chk("R9", "commit with coincident write", 64'(last_cm), 64'b010000);
        chk("R9", "only earlier bits", 64'(fld(4)), 64'h7777_1357);
        step(1'b0, 4'd0, 16'd0, 2'b00, 2'b11);
        chk("R9", "second commit", 64'(last_cm), 64'b010000);
        chk("R9", "new txn applied", 64'(fld(4)), 64'h2468_1357);
        step(1'b0, 4'd0, 16'd0, 2'b00, 2'b11);
        chk("R5", "drained trigger ignored", 64'(last_cm), 64'd0);
    endtask

    task automatic t_out_of_range();
        step(1'b1, 4'd12, 16'hFFFF, 2'b11, EXT_IDLE);
        step(1'b1, 4'd13, 16'hFFFF, 2'b11, EXT_IDLE);
        step(1'b1, 4'd15, 16'hFFFF, 2'b11, EXT_IDLE);
        chk("R11", "no commit", 64'(last_cm), 64'd0);
        step(1'b0, 4'd0, 16'd0, 2'b00, 2'b01);
        chk("R11", "nothing buffered", 64'(last_cm), 64'd0);
        chk("R11", "reg0 kept", 64'(fld(0)), 64'h56FE_BE12);
        chk("R11", "reg5 kept", 64'(fld(5)), 64'hA5A5_0101);
    endtask

    task automatic t_reset_pending();
        step(1'b1, 4'd8, 16'h9999, 2'b11, EXT_IDLE);
        do_reset();
        chk("R10", "reg4 back to reset", 64'(fld(4)), 64'(RSTV));
        step(1'b0, 4'd0, 16'd0, 2'b00, 2'b11);
        chk("R10", "pending cleared", 64'(last_cm), 64'd0);
        chk("R10", "reg4 still reset", 64'(fld(4)), 64'(RSTV));
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_ignore_peer();
        t_self();
        t_peer_group();
        t_strobe();
        t_accum_ext_high();
        t_ext_low();
        t_overlap();
        t_out_of_range();
        t_reset_pending();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule